// File: doc/BRIEF.md
# Programmable Memory-Access Write Port

This block holds the write side of a DSP's programmable memory-access register. A 32-bit control word packs a 16-bit mode in bits [31:16] and a 16-bit word address in bits [15:0]. Each data write strobe decodes the mode with fixed bit masks. It then sends a 16-bit word either to an external DRAM word array or to a small instruction RAM, and advances the stored control word by a step that the mode selects.

A DRAM mode can ask for a nibble-merge write instead of a plain replace. In that case the port first reads the addressed word, then writes back the merged word one cycle later. Modes that match no pattern, certain reserved bit combinations and instruction-RAM writes outside the expected window raise a one-cycle anomaly pulse. All outputs are registered and appear in the cycle after the strobe is sampled.

Top module: `pmac_write_port`

## Requirements
- R1: After reset `ctl_q` is 0 and `dram_we`, `dram_re`, `iram_we` and `anomaly` are low.
- R2: A strobe whose mode satisfies (mode & 0x43FF) == 0x0018 with mode bit 10 clear is a linear DRAM write. In the next cycle `dram_we`=1, `dram_addr` is the address field and `dram_wdata` is the strobe data.
- R3: After a linear DRAM or IRAM write, `ctl_q` increases by the step. The step magnitude is 0 when mode[13:11]=0 and 2^(mode[13:11]-1) otherwise. Mode bit 15 negates the step. The step is added to the full 32-bit word, so a carry or borrow out of the address reaches the mode field.
- R4: A strobe whose mode satisfies (mode & 0xFBFF) == 0x4018 is a cell-stepped DRAM write. It writes as in R2 and then adds 31 to `ctl_q` if the address was odd, or 1 if it was even.
- R5: For either DRAM mode with mode bit 10 set, the next cycle shows `dram_re`=1 at the address. The cycle after that shows `dram_we`=1 at the same address. Each nonzero data nibble replaces the matching nibble of `dram_rdata`, and each zero nibble keeps the old one.
- R6: A strobe that arrives in the cycle where `dram_re` is high is ignored. It causes no write, no step and no anomaly.
- R7: A strobe whose mode satisfies (mode & 0x47FF) == 0x001C writes the data to `iram_addr` = address[9:0] in the next cycle and steps as in R3.
- R8: An IRAM write whose address bits [15:10] are not 6'b100000 still writes and also pulses `anomaly` in the same cycle as `iram_we`.
- R9: A strobe whose mode has all of bits 15, 13, 12 and 11 set pulses `anomaly`. Any write or step it decodes to still happens.
- R10: A strobe whose mode matches none of R2, R4 and R7 performs no write and no step, and pulses `anomaly`.
- R11: A load (`ld_en`) sets `ctl_q` to `ld_word` in the next cycle. It overrides any step from a strobe in the same cycle, and that strobe still uses the old control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Load control word |
| ld_word | input | 32 | New control word (mode in [31:16], address in [15:0]) |
| wr_en | input | 1 | Data write strobe |
| wr_data | input | 16 | Data word to write |
| ctl_q | output | 32 | Current control word |
| dram_we | output | 1 | DRAM write enable |
| dram_re | output | 1 | DRAM read request for a merge |
| dram_addr | output | 16 | DRAM word address |
| dram_wdata | output | 16 | DRAM write data |
| dram_rdata | input | 16 | DRAM word at `dram_addr`, valid while `dram_re` is high |
| iram_we | output | 1 | Instruction RAM write enable |
| iram_addr | output | 10 | Instruction RAM word index |
| iram_wdata | output | 16 | Instruction RAM write data |
| anomaly | output | 1 | One-cycle anomaly pulse |

## Verification
Two functions can meet in one cycle: a control-word load and a write strobe that would step the same register. A strobe can also land in the read cycle of a pending merge. The random stimulus asserts `ld_en` and `wr_en` together often and issues strobes back to back after merge writes, so both collisions occur. The bench model judges them by the rules that the strobe uses the old word while the load wins the register, and that a strobe during the read cycle leaves `ctl_q` and every write output untouched.

// File: rtl/pmac_write_port.sv
module pmac_write_port #(
  parameter int DW  = 16,
  parameter int IAW = 10
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_en,
  input  logic [31:0]   ld_word,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [31:0]   ctl_q,
  output logic          dram_we,
  output logic          dram_re,
  output logic [15:0]   dram_addr,
  output logic [DW-1:0] dram_wdata,
  input  logic [DW-1:0] dram_rdata,
  output logic          iram_we,
  output logic [IAW-1:0] iram_addr,
  output logic [DW-1:0] iram_wdata,
  output logic          anomaly
);
  localparam int NIB = DW / 4;

  logic [15:0]   mode, addr;
  logic          is_lin, is_cell, is_iram, hit, go, bad;
  logic [2:0]    sel;
  logic [31:0]   mag, step, inc;
  logic [DW-1:0] hold, merged;

  assign mode    = ctl_q[31:16];
  assign addr    = ctl_q[15:0];
  assign is_lin  = (mode & 16'h43FF) == 16'h0018;
  assign is_cell = (mode & 16'hFBFF) == 16'h4018;
  assign is_iram = (mode & 16'h47FF) == 16'h001C;
  assign hit     = is_lin | is_cell | is_iram;
  assign go      = wr_en & ~dram_re;

  assign sel  = mode[13:11];
  assign mag  = (sel == 3'd0) ? 32'd0 : (32'd1 << (sel - 3'd1));
  assign step = mode[15] ? (~mag + 32'd1) : mag;
  assign inc  = is_cell ? (addr[0] ? 32'd31 : 32'd1) : step;

  assign bad = ((mode & 16'hB800) == 16'hB800) | ~hit |
               (is_iram & (addr[15:10] != 6'b100000));

  for (genvar n = 0; n < NIB; n++) begin : g_nib
    assign merged[4*n +: 4] = (hold[4*n +: 4] != 4'd0) ? hold[4*n +: 4]
                                                        : dram_rdata[4*n +: 4];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (ld_en) begin
      ctl_q <= ld_word;
    end else if (go && hit) begin
      ctl_q <= ctl_q + inc;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dram_we    <= 1'b0;
      dram_re    <= 1'b0;
      dram_addr  <= '0;
      dram_wdata <= '0;
      iram_we    <= 1'b0;
      iram_addr  <= '0;
      iram_wdata <= '0;
      anomaly    <= 1'b0;
      hold       <= '0;
    end else begin
      dram_we <= 1'b0;
      dram_re <= 1'b0;
      iram_we <= 1'b0;
      anomaly <= 1'b0;
      if (dram_re) begin
        dram_we    <= 1'b1;
        dram_wdata <= merged;
      end else if (go) begin
        anomaly <= bad;
        if (is_lin || is_cell) begin
          dram_addr <= addr;
          if (mode[10]) begin
            dram_re <= 1'b1;
            hold    <= wr_data;
          end else begin
            dram_we    <= 1'b1;
            dram_wdata <= wr_data;
          end
        end
        if (is_iram) begin
          iram_we    <= 1'b1;
          iram_addr  <= addr[IAW-1:0];
          iram_wdata <= wr_data;
        end
      end
    end
  end

  assert_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dram_we, dram_re, iram_we}));

  assert_merge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dram_re |=> dram_we && $stable(dram_addr));

  assert_ignore_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dram_re && wr_en && !ld_en |=> $stable(ctl_q) && !iram_we && !anomaly);

  assert_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> ctl_q == $past(ld_word));

  assert_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en && !ld_en && !dram_re |=> $stable(ctl_q) && !anomaly && !iram_we && !dram_re);
endmodule

// File: tb/pmac_write_port_tb.sv
`timescale 1ns/1ps
module pmac_write_port_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_en = 1'b0;
  logic [31:0] ld_word = '0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [31:0] ctl_q;
  logic        dram_we, dram_re, iram_we, anomaly;
  logic [15:0] dram_addr, dram_wdata, dram_rdata, iram_wdata;
  logic [9:0]  iram_addr;

  int errors = 0;
  int checks = 0;
  logic [15:0] mem [256];

  always #4 clk = ~clk;

  pmac_write_port u_dut (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_word(ld_word),
    .wr_en(wr_en), .wr_data(wr_data), .ctl_q(ctl_q),
    .dram_we(dram_we), .dram_re(dram_re), .dram_addr(dram_addr),
    .dram_wdata(dram_wdata), .dram_rdata(dram_rdata),
    .iram_we(iram_we), .iram_addr(iram_addr), .iram_wdata(iram_wdata),
    .anomaly(anomaly)
  );

  assign dram_rdata = mem[dram_addr[7:0]];
  always @(posedge clk) if (dram_we) mem[dram_addr[7:0]] <= dram_wdata;

  logic [31:0] m_ctl = '0;
  logic        m_pend = 1'b0;
  logic [15:0] m_paddr = '0, m_pdata = '0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] f_inc(input logic [31:0] c);
    logic [15:0] md;
    logic [31:0] mg;
    md = c[31:16];
    if ((md & 16'hFBFF) == 16'h4018) return c[0] ? 32'd31 : 32'd1;
    mg = (md[13:11] == 3'd0) ? 32'd0 : (32'd1 << (md[13:11] - 1));
    return md[15] ? -mg : mg;
  endfunction

  function automatic logic [15:0] f_merge(input logic [15:0] old, input logic [15:0] d);
    logic [15:0] r;
    for (int n = 0; n < 4; n++) r[4*n +: 4] = (d[4*n +: 4] != 0) ? d[4*n +: 4] : old[4*n +: 4];
    return r;
  endfunction

  task automatic cyc(input logic ld, input logic [31:0] lw, input logic wr, input logic [15:0] wd);
    logic [15:0] md, ad;
    logic lin, cel, irm, hitx;
    logic e_we, e_re, e_iwe, e_an;
    logic [15:0] e_addr, e_wd;
    logic [31:0] e_ctl;
    string t;
    ld_en = ld; ld_word = lw; wr_en = wr; wr_data = wd;
    md = m_ctl[31:16]; ad = m_ctl[15:0];
    lin = (md & 16'h43FF) == 16'h0018;
    cel = (md & 16'hFBFF) == 16'h4018;
    irm = (md & 16'h47FF) == 16'h001C;
    hitx = lin | cel | irm;
    e_we = 0; e_re = 0; e_iwe = 0; e_an = 0; e_addr = 0; e_wd = 0;
    e_ctl = m_ctl;
    t = "R2";
    if (m_pend) begin
      e_we = 1; e_addr = m_paddr; e_wd = f_merge(mem[m_paddr[7:0]], m_pdata);
      t = wr ? "R6" : "R5";
      m_pend = 0;
    end else if (wr) begin
      e_an = ((md & 16'hB800) == 16'hB800) || !hitx || (irm && ad[15:10] != 6'b100000);
      if (lin || cel) begin
        e_addr = ad;
        if (md[10]) begin e_re = 1; m_pend = 1; m_paddr = ad; m_pdata = wd; t = "R5"; end
        else begin e_we = 1; e_wd = wd; t = cel ? "R4" : "R2"; end
      end
      if (irm) begin e_iwe = 1; e_addr = ad; e_wd = wd; t = e_an ? "R8" : "R7"; end
      if (!hitx) t = "R10";
      else if ((md & 16'hB800) == 16'hB800) t = "R9";
      if (hitx) e_ctl = m_ctl + f_inc(m_ctl);
    end
    if (ld) begin e_ctl = lw; if (wr) t = "R11"; end
    @(posedge clk); #1;
    chk({t, " dram_we"}, dram_we, e_we);
    chk({t, " dram_re"}, dram_re, e_re);
    chk({t, " iram_we"}, iram_we, e_iwe);
    chk({t, " anomaly"}, anomaly, e_an);
    if (e_we || e_re) chk({t, " dram_addr"}, dram_addr, e_addr);
    if (e_we) chk({t, " dram_wdata"}, dram_wdata, e_wd);
    if (e_iwe) chk({t, " iram"}, {iram_addr, iram_wdata}, {e_addr[9:0], e_wd});
    chk((ld ? "R11 ctl" : (cel && wr ? "R4 ctl" : "R3 ctl")), ctl_q, e_ctl);
    m_ctl = e_ctl;
    @(negedge clk);
  endtask

  function automatic logic [31:0] rnd_word();
    logic [15:0] md, ad;
    int k;
    k = $urandom_range(0, 4);
    ad = $urandom_range(0, 1) ? {6'b100000, 10'($urandom)} : 16'($urandom);
    case (k)
      0: md = {1'($urandom), 1'b0, 3'($urandom), 1'($urandom), 10'h018};
      1: md = {2'b01, 3'b000, 1'($urandom), 10'h018};
      2: md = {1'($urandom), 1'b0, 3'($urandom), 1'b0, 10'h01C};
      3: md = {1'b1, 1'($urandom), 3'b111, 1'($urandom), 10'h018};
      default: md = 16'($urandom);
    endcase
    return {md, ad};
  endfunction

  initial begin
    #(8 * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5A17));
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    chk("R1 ctl", ctl_q, 32'd0);
    chk("R1 outs", {dram_we, dram_re, iram_we, anomaly}, 4'b0);
    rst_n = 1'b1;
    @(negedge clk);
    // directed corners
    cyc(1, 32'h0818_FFFF, 0, 0); cyc(0, 0, 1, 16'h1234);      // carry into mode, R3
    cyc(0, 0, 1, 16'h1111);                                    // now unmatched, R10
    cyc(1, 32'h8818_0000, 0, 0); cyc(0, 0, 1, 16'hBEEF);      // negative borrow, R3
    cyc(1, 32'h4018_0005, 0, 0); cyc(0, 0, 1, 16'h0A0A); cyc(0, 0, 1, 16'h0B0B); // R4
    cyc(1, 32'h0418_0007, 0, 0); cyc(0, 0, 1, 16'hFFFF);
    cyc(0, 0, 0, 0);
    cyc(1, 32'h0418_0007, 0, 0); cyc(0, 0, 1, 16'h0A00); cyc(0, 0, 1, 16'h5555); // R5 then R6
    cyc(1, 32'h101C_8003, 0, 0); cyc(0, 0, 1, 16'h7777);      // IRAM in window, R7
    cyc(1, 32'h081C_1003, 0, 0); cyc(0, 0, 1, 16'h6666);      // out of window, R8
    cyc(1, 32'hB818_0040, 0, 0); cyc(0, 0, 1, 16'h4242);      // reserved bits, R9
    cyc(1, 32'h0818_0010, 1, 16'h9999);                        // collision, R11
    for (int i = 0; i < 4000; i++) begin
      logic ld, wr;
      ld = ($urandom_range(0, 5) == 0);
      wr = ($urandom_range(0, 3) != 0);
      cyc(ld, rnd_word(), wr, 16'($urandom) & {4{4'($urandom_range(0, 1) ? 4'hF : 4'h0)}} | 16'($urandom_range(0, 1) ? $urandom : 0));
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule